// File: doc/BRIEF.md
# Multi-Channel I2C Interrupt Combiner

This block gathers interrupt events from a set of I2C bus channels and merges them into one interrupt line. Each channel has a 15-bit event status register and a 15-bit enable register. The channel's sequencer sets status bits with single-cycle event pulses. Software clears status bits by writing ones to them. When a channel raises an interrupt, its status is reduced to the enabled bits. If anything is left, the channel's bit in a shared pending register is set and the output line goes high.

The status bit positions are fixed, because the channel sequencers drive them:

| Bit | Event |
|-----|-------|
| 0 | byte acknowledged |
| 1 | byte not acknowledged |
| 2 | receive done |
| 3 | arbitration lost |
| 4 | stop completed |
| 5 | stop issued while idle |
| 6 | clock-line timeout |
| 13 | bus recovery finished |
| 14 | data-line timeout |

A receive can be chained. Suppose software clears the receive-done bit while that bit is set and the channel still has a receive command waiting. The block then sends the channel a one-cycle fetch pulse and, in the same cycle, runs the channel's raise step again. That raise step picks up the next receive-done event.

The register port has a write side and a read side, each addressed by a 2-bit register select and a channel index. The read side is combinational.

Top module: `i2c_irq_combiner`

## Requirements
- R1: After reset, every enable register, every status register, the pending register and every fetch pulse read zero, and `irq_o` is low.
- R2: A write with select 1 (enable) to channel c loads bits [14:0] of the write data into that channel's enable register. A read with select 1 returns that value with bits [31:15] zero.
- R3: An event pulse on bit b of channel c sets status bit b on the next clock edge. The bit stays set until it is cleared.
- R4: A write with select 2 (status) to channel c clears the status bits where write data bits [14:0] are one. Zero bits in the write data leave their status bits unchanged.
- R5: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R6: When `raise_i[c]` is high, the channel's next status is its cleared-and-event-merged value ANDed with its current enable register.
- R7: If the result of a raise step is non-zero, the channel's pending bit (bit c of the select-0 read) is set.
- R8: `irq_o` is high exactly while at least one pending bit is set. It stays high while any channel is still pending.
- R9: A channel's pending bit clears only on a status write to that channel that leaves its status at zero. A partial clear keeps the pending bit set.
- R10: Writes with select 0 (pending register) or select 3 have no effect. Writes to a channel index at or above the channel count have no effect.
- R11: `rx_fetch_o[c]` pulses for exactly one cycle, one cycle after a status write to channel c, when that write has data bit 2 set, status bit 2 was set, and `rx_pend_i[c]` was high. In every other case it stays low.
- R12: In the cycle in which `rx_fetch_o[c]` is high, channel c performs a raise step, just as if `raise_i[c]` were high.
- R13: The read select picks the source. Select 0 returns the pending register, zero-extended. Select 1 returns the enable register and select 2 the status register of channel `rd_ch_i`. Select 3, or a channel index out of range, returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_i | input | NUM_CH*STS_W | Event pulses; channel c uses bits [c*STS_W +: STS_W] |
| raise_i | input | NUM_CH | Per-channel raise request |
| rx_pend_i | input | NUM_CH | Per-channel receive command waiting |
| wr_valid_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 pending, 1 enable, 2 status, 3 none |
| wr_ch_i | input | CHW | Write channel index |
| wr_data_i | input | DW | Write data |
| rd_sel_i | input | 2 | Read source select |
| rd_ch_i | input | CHW | Read channel index |
| rd_data_o | output | DW | Read data (combinational) |
| irq_o | output | 1 | Combined interrupt line |
| rx_fetch_o | output | NUM_CH | Per-channel fetch-next-byte pulse |

## Verification
The assertions assume three things about the inputs. First, event pulses are the only source of new status bits. Second, `rx_pend_i` is stable around a clearing write. Third, the line can fall only after a status write. The stimulus respects all three: it drives events, raises and writes for a single cycle at a time, and holds `rx_pend_i` as a level across each receive sequence. The reference model in the bench applies the merge, mask and pending rules to the same inputs in every cycle. It predicts the line, the fetch pulses and the selected read word for each cycle.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  typedef enum logic [1:0] {
    SEL_PEND = 2'd0,
    SEL_EN   = 2'd1,
    SEL_STS  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // status bit positions decoded by the channel sequencers
  localparam int EV_ACK      = 0;
  localparam int EV_NAK      = 1;
  localparam int EV_RX_DONE  = 2;
  localparam int EV_ARB_LOSS = 3;
  localparam int EV_STOP     = 4;
  localparam int EV_BAD_STOP = 5;
  localparam int EV_SCL_TO   = 6;
  localparam int EV_RECOVER  = 13;
  localparam int EV_SDA_TO   = 14;
endpackage

// File: rtl/i2c_irq_chan.sv
module i2c_irq_chan
  import i2c_irq_pkg::*;
#(
  parameter int STS_W = 15,
  parameter int DW    = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [STS_W-1:0] evt_i,
  input  logic             raise_i,
  input  logic             rx_pend_i,
  input  logic             en_we_i,
  input  logic             sts_we_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [STS_W-1:0] en_o,
  output logic [STS_W-1:0] sts_o,
  output logic             pend_o,
  output logic             fetch_o
);
  logic [STS_W-1:0] en_q, sts_q, sts_d, clr, merged;
  logic             pend_q, pend_d, fetch_q, fetch_d, do_raise;

  assign clr      = sts_we_i ? wdata_i[STS_W-1:0] : '0;
  // events win over a clear of the same bit
  assign merged   = (sts_q & ~clr) | evt_i;
  assign do_raise = raise_i | fetch_q;
  assign sts_d    = do_raise ? (merged & en_q) : merged;
  assign fetch_d  = sts_we_i & wdata_i[EV_RX_DONE] & sts_q[EV_RX_DONE] & rx_pend_i;

  always_comb begin
    pend_d = pend_q;
    if (do_raise && (|sts_d))       pend_d = 1'b1;
    else if (sts_we_i && !(|sts_d)) pend_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      sts_q   <= '0;
      pend_q  <= 1'b0;
      fetch_q <= 1'b0;
    end else begin
      if (en_we_i) en_q <= wdata_i[STS_W-1:0];
      sts_q   <= sts_d;
      pend_q  <= pend_d;
      fetch_q <= fetch_d;
    end
  end

  assign en_o    = en_q;
  assign sts_o   = sts_q;
  assign pend_o  = pend_q;
  assign fetch_o = fetch_q;

  // R3
  sts_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sts_q & ~$past(sts_q) & ~$past(evt_i)) == '0));
  // R6
  raise_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(raise_i || fetch_q) |-> ((sts_q & ~$past(en_q)) == '0));
  // R7
  pend_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(raise_i || fetch_q));
  // R9
  pend_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pend_q) |-> ($past(sts_we_i) && (sts_q == '0)));
  // R11
  fetch_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_q |-> ($past(sts_q[EV_RX_DONE]) && $past(rx_pend_i) && $past(sts_we_i)));
endmodule

// File: rtl/i2c_irq_rd_mux.sv
module i2c_irq_rd_mux
  import i2c_irq_pkg::*;
#(
  parameter int NUM_CH = 14,
  parameter int STS_W  = 15,
  parameter int DW     = 32,
  parameter int CHW    = 4
) (
  input  logic [1:0]                   sel_i,
  input  logic [CHW-1:0]               ch_i,
  input  logic [NUM_CH-1:0]            pend_i,
  input  logic [NUM_CH-1:0][STS_W-1:0] en_i,
  input  logic [NUM_CH-1:0][STS_W-1:0] sts_i,
  output logic [DW-1:0]                data_o
);
  logic ch_ok;
  assign ch_ok = (int'(ch_i) < NUM_CH);

  always_comb begin
    data_o = '0;
    unique case (reg_sel_e'(sel_i))
      SEL_PEND: data_o[NUM_CH-1:0] = pend_i;
      SEL_EN:   if (ch_ok) data_o[STS_W-1:0] = en_i[ch_i];
      SEL_STS:  if (ch_ok) data_o[STS_W-1:0] = sts_i[ch_i];
      default:  data_o = '0;
    endcase
  end
endmodule

// File: rtl/i2c_irq_combiner.sv
module i2c_irq_combiner
  import i2c_irq_pkg::*;
#(
  parameter  int NUM_CH = 14,
  parameter  int STS_W  = 15,
  parameter  int DW     = 32,
  localparam int CHW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_CH*STS_W-1:0] evt_i,
  input  logic [NUM_CH-1:0]       raise_i,
  input  logic [NUM_CH-1:0]       rx_pend_i,
  input  logic                    wr_valid_i,
  input  logic [1:0]              wr_sel_i,
  input  logic [CHW-1:0]          wr_ch_i,
  input  logic [DW-1:0]           wr_data_i,
  input  logic [1:0]              rd_sel_i,
  input  logic [CHW-1:0]          rd_ch_i,
  output logic [DW-1:0]           rd_data_o,
  output logic                    irq_o,
  output logic [NUM_CH-1:0]       rx_fetch_o
);
  logic [NUM_CH-1:0][STS_W-1:0] en_all, sts_all;
  logic [NUM_CH-1:0]            pend_all;
  logic                         wr_en, wr_sts;

  assign wr_en  = wr_valid_i && (reg_sel_e'(wr_sel_i) == SEL_EN);
  assign wr_sts = wr_valid_i && (reg_sel_e'(wr_sel_i) == SEL_STS);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = (wr_ch_i == CHW'(c));

    i2c_irq_chan #(.STS_W(STS_W), .DW(DW)) i_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .evt_i     (evt_i[c*STS_W +: STS_W]),
      .raise_i   (raise_i[c]),
      .rx_pend_i (rx_pend_i[c]),
      .en_we_i   (wr_en && hit),
      .sts_we_i  (wr_sts && hit),
      .wdata_i   (wr_data_i),
      .en_o      (en_all[c]),
      .sts_o     (sts_all[c]),
      .pend_o    (pend_all[c]),
      .fetch_o   (rx_fetch_o[c])
    );
  end

  i2c_irq_rd_mux #(.NUM_CH(NUM_CH), .STS_W(STS_W), .DW(DW), .CHW(CHW)) i_rd_mux (
    .sel_i  (rd_sel_i),
    .ch_i   (rd_ch_i),
    .pend_i (pend_all),
    .en_i   (en_all),
    .sts_i  (sts_all),
    .data_o (rd_data_o)
  );

  assign irq_o = |pend_all;

  // R8
  irq_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(wr_valid_i && (reg_sel_e'(wr_sel_i) == SEL_STS)));
endmodule

// File: tb/test_i2c_irq_combiner.sv
`timescale 1ns/1ps
module test_i2c_irq_combiner;
  localparam int NCH = 14;
  localparam int SW  = 15;
  localparam int MSK = 'h7FFF;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic [NCH*SW-1:0] evt = '0;
  logic [NCH-1:0]  raise = '0, rx_pend = '0;
  logic            wv = 1'b0;
  logic [1:0]      wsel = '0, rsel = '0;
  logic [3:0]      wch = '0, rch = '0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic            irq;
  logic [NCH-1:0]  fetch;

  int checks = 0, errors = 0;
  string cur_req = "R1";
  int m_en[NCH], m_sts[NCH];
  bit m_pend[NCH], m_fetch[NCH];

  always #4 clk = ~clk;

  i2c_irq_combiner i_i2c_irq_combiner (
    .clk_i(clk), .rst_ni(rst_ni), .evt_i(evt), .raise_i(raise), .rx_pend_i(rx_pend),
    .wr_valid_i(wv), .wr_sel_i(wsel), .wr_ch_i(wch), .wr_data_i(wdata),
    .rd_sel_i(rsel), .rd_ch_i(rch), .rd_data_o(rdata), .irq_o(irq), .rx_fetch_o(fetch)
  );

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  function automatic int exp_rd();
    int r = 0;
    case (rsel)
      2'd0: for (int c = 0; c < NCH; c++) if (m_pend[c]) r |= (1 << c);
      2'd1: r = (int'(rch) < NCH) ? m_en[rch] : 0;
      2'd2: r = (int'(rch) < NCH) ? m_sts[rch] : 0;
      default: r = 0;
    endcase
    return r;
  endfunction

  task automatic compare();
    int f = 0, fx = 0;
    bit any = 0;
    for (int c = 0; c < NCH; c++) begin
      if (m_fetch[c]) fx |= (1 << c);
      if (m_pend[c]) any = 1;
    end
    f = int'(fetch);
    chk("irq", int'(irq), int'(any));
    chk("fetch", f, fx);
    chk("rd_data", int'(rdata), exp_rd());
  endtask

  // advance one clock with current inputs, update model, compare
  task automatic tick();
    int n_en[NCH], n_sts[NCH];
    bit n_pend[NCH], n_fetch[NCH];
    for (int c = 0; c < NCH; c++) begin
      bit hit = wv && (int'(wch) == c);
      bit swe = hit && (wsel == 2'd2);
      int clr = swe ? (int'(wdata) & MSK) : 0;
      int ev  = int'(evt[c*SW +: SW]);
      int b   = (m_sts[c] & ~clr) | ev;
      bit r   = raise[c] || m_fetch[c];
      if (r) b &= m_en[c];
      n_sts[c]  = b;
      n_en[c]   = (hit && wsel == 2'd1) ? (int'(wdata) & MSK) : m_en[c];
      n_pend[c] = m_pend[c];
      if (r && b != 0) n_pend[c] = 1;
      else if (swe && b == 0) n_pend[c] = 0;
      n_fetch[c] = swe && wdata[2] && ((m_sts[c] >> 2) & 1) && rx_pend[c];
    end
    @(posedge clk);
    #2;
    m_en = n_en; m_sts = n_sts; m_pend = n_pend; m_fetch = n_fetch;
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(input int sel, input int ch, input int data);
    @(negedge clk);
    wv = 1'b1; wsel = 2'(sel); wch = 4'(ch); wdata = data;
    tick();
    @(negedge clk);
    wv = 1'b0;
  endtask

  task automatic ev(input int ch, input int bits, input bit rs);
    @(negedge clk);
    evt[ch*SW +: SW] = SW'(bits); raise[ch] = rs;
    tick();
    @(negedge clk);
    evt = '0; raise = '0;
  endtask

  task automatic rd(input int sel, input int ch);
    @(negedge clk);
    rsel = 2'(sel); rch = 4'(ch);
    #1;
    chk("read", int'(rdata), exp_rd());
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      m_en[c] = 0; m_sts[c] = 0; m_pend[c] = 0; m_fetch[c] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    cur_req = "R1";
    rd(0, 0); rd(1, 0); rd(2, 0); rd(2, 13);
    compare();
    idle(2);

    // R2 enable keeps low 15 bits
    cur_req = "R2";
    wr(1, 3, 'hFFFF_FFFF);
    rd(1, 3);
    wr(1, 3, 'h0007);
    rd(1, 3);

    // R3 events set status, no raise
    cur_req = "R3";
    rd(2, 3);
    ev(3, 'h0011, 0);
    idle(2);

    // R6 R7 raise masks with enable and sets pending
    cur_req = "R6";
    ev(3, 'h0000, 1);
    rd(0, 0);
    cur_req = "R7";
    idle(1);

    // R13 select 3 reads zero, out-of-range channel reads zero
    cur_req = "R13";
    rd(3, 3); rd(1, 15); rd(2, 14);

    // R10 writes to pending register / select 3 / out-of-range channel ignored
    cur_req = "R10";
    rd(0, 0);
    wr(0, 0, 'hFFFF_FFFF);
    wr(3, 0, 'hFFFF_FFFF);
    wr(1, 14, 'h7FFF);
    wr(2, 15, 'h7FFF);
    rd(2, 3);
    idle(1);

    // R8 two channels pending, line held until the last clears
    cur_req = "R8";
    wr(1, 5, 'h7FFF);
    ev(5, 'h0040, 1);
    rd(0, 0);
    wr(2, 3, 'h7FFF);
    idle(1);
    wr(2, 5, 'h0040);
    idle(1);

    // R9 partial clear keeps pending
    cur_req = "R9";
    ev(5, 'h6003, 1);
    wr(2, 5, 'h0001);
    idle(1);
    wr(2, 5, 'h6002);
    idle(1);

    // R4 zeros in clear data have no effect
    cur_req = "R4";
    ev(5, 'h0018, 0);
    rd(2, 5);
    wr(2, 5, 'h0000);
    wr(2, 5, 'h0008);
    wr(2, 5, 'h0010);

    // R5 event beats clear on the same bit
    cur_req = "R5";
    ev(3, 'h0001, 0);
    rd(2, 3);
    @(negedge clk);
    wv = 1'b1; wsel = 2'd2; wch = 4'd3; wdata = 'h0001;
    evt[3*SW +: SW] = SW'('h0001);
    tick();
    @(negedge clk);
    wv = 1'b0; evt = '0;
    wr(2, 3, 'h0001);

    // R11 R12 receive chaining
    cur_req = "R11";
    wr(1, 7, 'h0004);
    ev(7, 'h0005, 1);
    rd(0, 0);
    @(negedge clk);
    rx_pend[7] = 1'b1;
    wv = 1'b1; wsel = 2'd2; wch = 4'd7; wdata = 'h0004;
    tick();
    @(negedge clk);
    wv = 1'b0;
    cur_req = "R12";
    evt[7*SW +: SW] = SW'('h0006);
    tick();
    @(negedge clk);
    evt = '0;
    rd(2, 7);
    idle(1);
    cur_req = "R11";
    rx_pend[7] = 1'b0;
    wr(2, 7, 'h0004);
    idle(2);
    rx_pend[7] = 1'b1;
    wr(2, 7, 'h0004);
    idle(2);
    ev(7, 'h0004, 0);
    @(negedge clk);
    rx_pend[7] = 1'b0;
    wr(2, 7, 'h0004);
    idle(1);

    // R1 reset mid-run
    cur_req = "R1";
    ev(7, 'h0004, 1);
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    for (int c = 0; c < NCH; c++) begin
      m_en[c] = 0; m_sts[c] = 0; m_pend[c] = 0; m_fetch[c] = 0;
    end
    rsel = 2'd0;
    #1;
    compare();
    @(negedge clk);
    rst_ni = 1'b1;
    rd(1, 7);
    idle(2);
    finish_run();
  end
endmodule